// File: doc/BRIEF.md
# SHA-256 Compression Core with Lookahead Round Sum

This core performs one SHA-256 compression: it folds a single 512-bit message block into a 256-bit chaining value and returns the updated 256-bit hash. A request is presented on `start_i` together with `chain_i` and `block_i`. The core captures both, then runs the 64 rounds at one round per clock. It adds the working words back into the captured chaining value and reports the result on `digest_o` with a one-cycle `done_o` pulse. Message padding, chaining of several blocks and any outer iteration are handled outside the core.

Each round needs the sum h + K[i] + W[i]. With `LOOKAHEAD = 1` this sum is formed during the previous round and stored in a register. It is built from that round's g, which becomes the next h, together with the next constant and the next schedule word. The round's own adders then only combine the stored sum with Σ1(e) and Ch(e,f,g). With `LOOKAHEAD = 0` the core forms the full sum inside the round. Both settings produce the same digest on the same cycle. The schedule words are produced by a 16-entry rolling window that is loaded from the block and extended one word per round.

Top module: `sha_lk_core`

## Requirements
- R1: When the core is idle and `start_i` is high at a rising clock edge, the core captures `chain_i` and `block_i` on that edge and `busy_o` is high from the next cycle. Later changes on those inputs do not affect the result.
- R2: While `busy_o` is high, `start_i` is ignored. A pulse on it during the rounds, or in the cycle before `done_o`, neither changes the digest nor starts another run.
- R3: In every round the new b, c, d, f, g and h take the previous a, b, c, e, f and g.
- R4: In every round the new e is d + t1 and the new a is t1 + t2, where t1 = h + Σ1(e) + Ch(e,f,g) + K[i] + W[i] and t2 = Σ0(a) + Maj(a,b,c), all modulo 2^32.
- R5: With `LOOKAHEAD = 1`, a register holds h + K[i] + W[i] for the round i being executed. It is formed one cycle ahead from the then-current g, K[i+1] and W[i+1].
- R6: W[0..15] are the block words, with word 0 at bits 511:480. For i from 16 to 63, W[i] = σ1(W[i-2]) + W[i-7] + σ0(W[i-15]) + W[i-16].
- R7: The digest is the word-wise modulo-2^32 sum of the captured chaining value and the final working words, with a in bits 255:224 and h in bits 31:0. It holds until the next completion.
- R8: `done_o` is high for exactly one cycle, 65 clock edges after the accepting edge. `busy_o` is low in that same cycle.
- R9: During and right after reset, `busy_o` and `done_o` are low and `digest_o` is zero.
- R10: Given the standard initial hash value, the padded empty message gives e3b0c442...7852b855, and the padded "abc" message gives ba7816bf...f20015ad.
- R11: `LOOKAHEAD = 0` and `LOOKAHEAD = 1` give identical digests with identical timing for any input.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Request a compression; taken only while idle |
| chain_i | input | 256 | Chaining value, word a in the top bits |
| block_i | input | 512 | Message block, word 0 in the top bits |
| busy_o | output | 1 | High while a compression is in progress |
| done_o | output | 1 | One-cycle pulse when `digest_o` is updated |
| digest_o | output | 256 | Updated hash value, word a in the top bits |

## Verification
The hardest case to reach from the ports is an error in the lookahead register that shows up in only one round. Examples are the hand-over at load time, where the first sum has to come straight from the input word, and the last round, where the look-ahead index wraps. Both surface only as a changed digest. The bench therefore compares each digest with an independent plain reference model and with a second instance built with `LOOKAHEAD = 0`. It runs blocks chosen to excite every word position: all zeros, all ones, a repeated pattern, and the two padded standard messages. It also pulses `start_i` in the middle of a run and in the final cycle, while scrambling the data inputs after each accept.

// File: rtl/sha_lk_pkg.sv
package sha_lk_pkg;
   localparam int WORD_W     = 32;
   localparam int NUM_WORDS  = 8;
   localparam int BLK_WORDS  = 16;
   localparam int NUM_ROUNDS = 64;
   localparam int RND_W      = $clog2(NUM_ROUNDS);
   localparam int HASH_W     = WORD_W * NUM_WORDS;
   localparam int BLK_W      = WORD_W * BLK_WORDS;

   typedef logic [WORD_W-1:0] word_t;
   typedef logic [NUM_WORDS-1:0][WORD_W-1:0] hash_t;
   typedef enum logic [1:0] {ST_IDLE, ST_RUN, ST_FIN} core_st_e;

   function automatic word_t rotr(word_t x, int unsigned n);
      return (x >> n) | (x << (WORD_W - n));
   endfunction

   function automatic word_t big_s0(word_t x);
      return rotr(x, 2) ^ rotr(x, 13) ^ rotr(x, 22);
   endfunction

   function automatic word_t big_s1(word_t x);
      return rotr(x, 6) ^ rotr(x, 11) ^ rotr(x, 25);
   endfunction

   function automatic word_t sm_s0(word_t x);
      return rotr(x, 7) ^ rotr(x, 18) ^ (x >> 3);
   endfunction

   function automatic word_t sm_s1(word_t x);
      return rotr(x, 17) ^ rotr(x, 19) ^ (x >> 10);
   endfunction

   function automatic word_t choose(word_t x, word_t y, word_t z);
      return (x & y) ^ (~x & z);
   endfunction

   function automatic word_t majority(word_t x, word_t y, word_t z);
      return (x & y) ^ (x & z) ^ (y & z);
   endfunction

   function automatic word_t round_k(logic [RND_W-1:0] i);
      word_t k;
      case (i)
         6'd0:  k = 32'h428a2f98; 6'd1:  k = 32'h71374491; 6'd2:  k = 32'hb5c0fbcf; 6'd3:  k = 32'he9b5dba5;
         6'd4:  k = 32'h3956c25b; 6'd5:  k = 32'h59f111f1; 6'd6:  k = 32'h923f82a4; 6'd7:  k = 32'hab1c5ed5;
         6'd8:  k = 32'hd807aa98; 6'd9:  k = 32'h12835b01; 6'd10: k = 32'h243185be; 6'd11: k = 32'h550c7dc3;
         6'd12: k = 32'h72be5d74; 6'd13: k = 32'h80deb1fe; 6'd14: k = 32'h9bdc06a7; 6'd15: k = 32'hc19bf174;
         6'd16: k = 32'he49b69c1; 6'd17: k = 32'hefbe4786; 6'd18: k = 32'h0fc19dc6; 6'd19: k = 32'h240ca1cc;
         6'd20: k = 32'h2de92c6f; 6'd21: k = 32'h4a7484aa; 6'd22: k = 32'h5cb0a9dc; 6'd23: k = 32'h76f988da;
         6'd24: k = 32'h983e5152; 6'd25: k = 32'ha831c66d; 6'd26: k = 32'hb00327c8; 6'd27: k = 32'hbf597fc7;
         6'd28: k = 32'hc6e00bf3; 6'd29: k = 32'hd5a79147; 6'd30: k = 32'h06ca6351; 6'd31: k = 32'h14292967;
         6'd32: k = 32'h27b70a85; 6'd33: k = 32'h2e1b2138; 6'd34: k = 32'h4d2c6dfc; 6'd35: k = 32'h53380d13;
         6'd36: k = 32'h650a7354; 6'd37: k = 32'h766a0abb; 6'd38: k = 32'h81c2c92e; 6'd39: k = 32'h92722c85;
         6'd40: k = 32'ha2bfe8a1; 6'd41: k = 32'ha81a664b; 6'd42: k = 32'hc24b8b70; 6'd43: k = 32'hc76c51a3;
         6'd44: k = 32'hd192e819; 6'd45: k = 32'hd6990624; 6'd46: k = 32'hf40e3585; 6'd47: k = 32'h106aa070;
         6'd48: k = 32'h19a4c116; 6'd49: k = 32'h1e376c08; 6'd50: k = 32'h2748774c; 6'd51: k = 32'h34b0bcb5;
         6'd52: k = 32'h391c0cb3; 6'd53: k = 32'h4ed8aa4a; 6'd54: k = 32'h5b9cca4f; 6'd55: k = 32'h682e6ff3;
         6'd56: k = 32'h748f82ee; 6'd57: k = 32'h78a5636f; 6'd58: k = 32'h84c87814; 6'd59: k = 32'h8cc70208;
         6'd60: k = 32'h90befffa; 6'd61: k = 32'ha4506ceb; 6'd62: k = 32'hbef9a3f7; 6'd63: k = 32'hc67178f2;
         default: k = '0;
      endcase
      return k;
   endfunction
endpackage

// File: rtl/sha_lk_kconst.sv
module sha_lk_kconst
   import sha_lk_pkg::*;
(
   input  logic [RND_W-1:0] idx_i,
   output word_t            k_o
);
   assign k_o = round_k(idx_i);
endmodule

// File: rtl/sha_lk_sched.sv
module sha_lk_sched
   import sha_lk_pkg::*;
#(
   parameter int TAP = 0
)(
   input  logic             clk,
   input  logic             rst_n,
   input  logic             load_i,
   input  logic             adv_i,
   input  logic [BLK_W-1:0] block_i,
   output word_t            tap_o
);
   localparam int LAST = BLK_WORDS - 1;

   initial begin
      tap_range_chk : assert (TAP >= 0 && TAP < BLK_WORDS)
         else $error("sha_lk_sched: TAP out of window");
   end

   word_t win_q [BLK_WORDS];
   word_t fresh;

   // next schedule word from the sliding window
   assign fresh = sm_s1(win_q[BLK_WORDS-2]) + win_q[BLK_WORDS-7]
                + sm_s0(win_q[BLK_WORDS-15]) + win_q[BLK_WORDS-16];

   for (genvar k = 0; k < BLK_WORDS; k++) begin : g_win
      if (k == LAST) begin : g_tail
         always_ff @(posedge clk) begin
            if (load_i)     win_q[k] <= block_i[(LAST-k)*WORD_W +: WORD_W];
            else if (adv_i) win_q[k] <= fresh;
         end
      end else begin : g_body
         always_ff @(posedge clk) begin
            if (load_i)     win_q[k] <= block_i[(LAST-k)*WORD_W +: WORD_W];
            else if (adv_i) win_q[k] <= win_q[k+1];
         end
      end
   end

   assign tap_o = win_q[TAP];

   // R6
   win_shift_chk : assert property (@(posedge clk) disable iff (!rst_n)
      adv_i && !load_i |=> (win_q[0] == $past(win_q[1])) && (win_q[LAST-1] == $past(win_q[LAST])));
endmodule

// File: rtl/sha_lk_round.sv
module sha_lk_round
   import sha_lk_pkg::*;
(
   input  logic  clk,
   input  logic  rst_n,
   input  logic  load_i,
   input  logic  adv_i,
   input  hash_t chain_i,
   input  word_t hkw_i,
   output hash_t work_o
);
   hash_t st_q;
   word_t wa, wb, wc, wd, we, wf, wg;
   word_t t1, t2;

   assign wa = st_q[7]; assign wb = st_q[6]; assign wc = st_q[5]; assign wd = st_q[4];
   assign we = st_q[3]; assign wf = st_q[2]; assign wg = st_q[1];

   // hkw_i already carries h + K + W for this round
   assign t1 = hkw_i + big_s1(we) + choose(we, wf, wg);
   assign t2 = big_s0(wa) + majority(wa, wb, wc);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q <= '0;
      end else if (load_i) begin
         st_q <= chain_i;
      end else if (adv_i) begin
         st_q <= {t1 + t2, wa, wb, wc, wd + t1, we, wf, wg};
      end
   end

   assign work_o = st_q;

   // R3
   shift_copy_chk : assert property (@(posedge clk) disable iff (!rst_n)
      adv_i && !load_i |=> (st_q[6] == $past(st_q[7])) && (st_q[5] == $past(st_q[6]))
                        && (st_q[4] == $past(st_q[5])) && (st_q[2] == $past(st_q[3]))
                        && (st_q[1] == $past(st_q[2])) && (st_q[0] == $past(st_q[1])));

   // R4
   a_e_gap_chk : assert property (@(posedge clk) disable iff (!rst_n)
      adv_i && !load_i |=> word_t'(st_q[7] - st_q[3]) == $past(word_t'(t2 - st_q[4])));
endmodule

// File: rtl/sha_lk_core.sv
module sha_lk_core
   import sha_lk_pkg::*;
#(
   parameter int LOOKAHEAD = 1
)(
   input  logic                                 clk,
   input  logic                                 rst_n,
   input  logic                                 start_i,
   input  logic [sha_lk_pkg::HASH_W-1:0]        chain_i,
   input  logic [sha_lk_pkg::BLK_W-1:0]         block_i,
   output logic                                 busy_o,
   output logic                                 done_o,
   output logic [sha_lk_pkg::HASH_W-1:0]        digest_o
);
   localparam int TAP = (LOOKAHEAD != 0) ? 1 : 0;
   localparam logic [RND_W-1:0] LAST_RND = RND_W'(NUM_ROUNDS - 1);

   initial begin
      lookahead_opt_chk : assert (LOOKAHEAD == 0 || LOOKAHEAD == 1)
         else $error("sha_lk_core: LOOKAHEAD must be 0 or 1");
   end

   core_st_e         st_q;
   logic [RND_W-1:0] rnd_q;
   logic [RND_W-1:0] k_idx;
   hash_t            chain_w, chain_q, work, sum;
   word_t            k_sel, w_tap, hkw;
   logic             accept, adv;

   assign chain_w = chain_i;
   assign accept  = (st_q == ST_IDLE) && start_i;
   assign adv     = (st_q == ST_RUN);
   assign busy_o  = (st_q != ST_IDLE);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q     <= ST_IDLE;
         rnd_q    <= '0;
         done_o   <= 1'b0;
         digest_o <= '0;
         chain_q  <= '0;
      end else begin
         done_o <= 1'b0;
         unique case (st_q)
            ST_IDLE: if (start_i) begin
               st_q    <= ST_RUN;
               rnd_q   <= '0;
               chain_q <= chain_w;
            end
            ST_RUN: begin
               rnd_q <= rnd_q + 1'b1;
               if (rnd_q == LAST_RND) st_q <= ST_FIN;
            end
            ST_FIN: begin
               digest_o <= sum;
               done_o   <= 1'b1;
               st_q     <= ST_IDLE;
            end
            default: st_q <= ST_IDLE;
         endcase
      end
   end

   sha_lk_kconst u_kconst (.idx_i(k_idx), .k_o(k_sel));

   sha_lk_sched #(.TAP(TAP)) u_sched (
      .clk(clk), .rst_n(rst_n), .load_i(accept), .adv_i(adv),
      .block_i(block_i), .tap_o(w_tap)
   );

   sha_lk_round u_round (
      .clk(clk), .rst_n(rst_n), .load_i(accept), .adv_i(adv),
      .chain_i(chain_w), .hkw_i(hkw), .work_o(work)
   );

   if (LOOKAHEAD != 0) begin : g_ahead
      word_t p_q, w_feed;
      // while idle the first schedule word comes straight from the input block
      assign k_idx  = (st_q == ST_IDLE) ? '0 : RND_W'(rnd_q + 1'b1);
      assign w_feed = (st_q == ST_IDLE) ? block_i[BLK_W-1 -: WORD_W] : w_tap;

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)      p_q <= '0;
         else if (accept) p_q <= chain_w[0] + k_sel + w_feed;
         else if (adv)    p_q <= work[1] + k_sel + w_feed;
      end
      assign hkw = p_q;

      // R5
      ahead_sum_chk : assert property (@(posedge clk) disable iff (!rst_n)
         (st_q == ST_RUN) |-> p_q == word_t'(work[0] + round_k(rnd_q) + u_sched.win_q[0]));
   end else begin : g_plain
      assign k_idx = rnd_q;
      assign hkw   = work[0] + k_sel + w_tap;
   end

   for (genvar j = 0; j < NUM_WORDS; j++) begin : g_fold
      assign sum[j] = chain_q[j] + work[j];
   end

   // R8
   done_pulse_chk : assert property (@(posedge clk) disable iff (!rst_n)
      done_o |=> !done_o);

   // R8
   done_idle_chk : assert property (@(posedge clk) disable iff (!rst_n)
      done_o |-> !busy_o);

   // R1
   accept_busy_chk : assert property (@(posedge clk) disable iff (!rst_n)
      accept |=> busy_o && rnd_q == '0);

   // R2
   chain_hold_chk : assert property (@(posedge clk) disable iff (!rst_n)
      busy_o |=> $stable(chain_q));

   // R8
   round_step_chk : assert property (@(posedge clk) disable iff (!rst_n)
      (st_q == ST_RUN) && (rnd_q != LAST_RND) |=> (st_q == ST_RUN) && rnd_q == $past(rnd_q) + 1'b1);
endmodule

// File: tb/sha_lk_core_tb_top.sv
module sha_lk_core_tb_top;
   import sha_lk_pkg::*;

   localparam int CLK_PERIOD = 10;
   localparam int NV = 5;
   localparam logic [255:0] IV = 256'h6a09e667bb67ae853c6ef372a54ff53a510e527f9b05688c1f83d9ab5be0cd19;

   typedef struct packed {
      logic [255:0] cv;
      logic [511:0] blk;
      logic         has_kat;
      logic [255:0] kat;
   } vec_t;

   localparam vec_t VECS [NV] = '{
      '{IV, {32'h80000000, 448'h0, 32'h00000000}, 1'b1,
        256'he3b0c44298fc1c149afbf4c8996fb92427ae41e4649b934ca495991b7852b855},
      '{IV, {32'h61626380, 448'h0, 32'h00000018}, 1'b1,
        256'hba7816bf8f01cfea414140de5dae2223b00361a396177a9cb410ff61f20015ad},
      '{{256{1'b1}}, {512{1'b1}}, 1'b0, 256'h0},
      '{256'h0, 512'h0, 1'b0, 256'h0},
      '{256'h0123456789abcdeffedcba98765432100f1e2d3c4b5a69788796a5b4c3d2e1f0,
        {16{32'hA5C30F96}}, 1'b0, 256'h0}
   };

   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic         start = 1'b0;
   logic [255:0] chain_in = '0;
   logic [511:0] block_in = '0;
   logic         busy, done, busy_p, done_p;
   logic [255:0] digest, digest_p;
   int           checks = 0;
   int           errors = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   sha_lk_core #(.LOOKAHEAD(1)) dut_i (
      .clk(clk), .rst_n(rst_n), .start_i(start), .chain_i(chain_in), .block_i(block_in),
      .busy_o(busy), .done_o(done), .digest_o(digest)
   );

   sha_lk_core #(.LOOKAHEAD(0)) dut_plain_i (
      .clk(clk), .rst_n(rst_n), .start_i(start), .chain_i(chain_in), .block_i(block_in),
      .busy_o(busy_p), .done_o(done_p), .digest_o(digest_p)
   );

   function automatic logic [31:0] rr(logic [31:0] x, int n);
      return (x >> n) | (x << (32 - n));
   endfunction

   function automatic logic [255:0] ref_hash(logic [255:0] cv, logic [511:0] blk);
      logic [31:0] w [64];
      logic [31:0] a, b, c, d, e, f, g, h, t1, t2;
      for (int i = 0; i < 16; i++) w[i] = blk[511 - 32*i -: 32];
      for (int i = 16; i < 64; i++)
         w[i] = (rr(w[i-2], 17) ^ rr(w[i-2], 19) ^ (w[i-2] >> 10)) + w[i-7]
              + (rr(w[i-15], 7) ^ rr(w[i-15], 18) ^ (w[i-15] >> 3)) + w[i-16];
      {a, b, c, d, e, f, g, h} = cv;
      for (int i = 0; i < 64; i++) begin
         t1 = h + (rr(e, 6) ^ rr(e, 11) ^ rr(e, 25)) + ((e & f) ^ (~e & g))
            + round_k(6'(i)) + w[i];
         t2 = (rr(a, 2) ^ rr(a, 13) ^ rr(a, 22)) + ((a & b) ^ (a & c) ^ (b & c));
         h = g; g = f; f = e; e = d + t1;
         d = c; c = b; b = a; a = t1 + t2;
      end
      return {cv[255:224] + a, cv[223:192] + b, cv[191:160] + c, cv[159:128] + d,
              cv[127:96] + e, cv[95:64] + f, cv[63:32] + g, cv[31:0] + h};
   endfunction

   task automatic chk(input bit ok, input string req, input logic [255:0] act, input logic [255:0] exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   // one full compression; poke pulses start during the run and in the final state
   task automatic run_block(input logic [255:0] cv, input logic [511:0] blk, input bit poke,
                            output logic [255:0] dg, output logic [255:0] dgp);
      @(negedge clk);
      start = 1'b1; chain_in = cv; block_in = blk;
      @(negedge clk);
      start = 1'b0; chain_in = ~cv; block_in = ~blk;
      chk(busy == 1'b1, "R1 busy after accept", {255'b0, busy}, 256'd1);
      for (int c = 1; c <= 64; c++) begin
         @(negedge clk);
         if (poke && (c == 20 || c == 64)) begin
            start = 1'b1; block_in = {16{32'h5A5A5A5A}};
         end else start = 1'b0;
      end
      chk(done == 1'b0 && busy == 1'b1, "R8 no done before edge 65", {254'b0, done, busy}, 256'd1);
      @(negedge clk);
      start = 1'b0;
      chk(done == 1'b1, "R8 done on edge 65", {255'b0, done}, 256'd1);
      chk(busy == 1'b0, "R2 R8 idle with done, no restart", {255'b0, busy}, 256'd0);
      dg = digest; dgp = digest_p;
      @(negedge clk);
      chk(done == 1'b0 && busy == 1'b0, "R8 done single cycle", {254'b0, done, busy}, 256'd0);
      chk(digest == dg, "R7 digest held", digest, dg);
   endtask

   initial begin : watchdog
      repeat (20000) @(posedge clk);
      errors++;
      $display("FAIL watchdog expired actual=timeout expected=finish");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin : main
      logic [255:0] dg, dgp, ex;
      repeat (3) @(negedge clk);
      // R9
      chk(busy == 1'b0 && done == 1'b0, "R9 reset flags", {254'b0, busy, done}, 256'd0);
      chk(digest == '0, "R9 reset digest", digest, 256'd0);
      rst_n = 1'b1;
      @(negedge clk);
      chk(busy == 1'b0 && done == 1'b0 && digest == '0, "R9 after release", digest, 256'd0);

      for (int v = 0; v < NV; v++) begin
         run_block(VECS[v].cv, VECS[v].blk, 1'b0, dg, dgp);
         ex = ref_hash(VECS[v].cv, VECS[v].blk);
         chk(dg == ex, "R3 R4 R6 R7 digest vs reference", dg, ex);
         if (VECS[v].has_kat) chk(dg == VECS[v].kat, "R10 known digest", dg, VECS[v].kat);
         chk(dgp == dg, "R5 R11 lookahead vs plain", dgp, dg);
      end

      // R2: start pulses while busy must not disturb the run
      run_block(IV, VECS[1].blk, 1'b1, dg, dgp);
      chk(dg == VECS[1].kat, "R2 start ignored while busy", dg, VECS[1].kat);
      chk(dgp == dg, "R11 plain under poke", dgp, dg);

      // R1: chaining a second block from the first result
      run_block(dg, VECS[4].blk, 1'b0, dg, dgp);
      ex = ref_hash(VECS[1].kat, VECS[4].blk);
      chk(dg == ex, "R1 R7 chained block", dg, ex);

      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule